// File: doc/BRIEF.md
# Two-Channel Tamper Detector

This block watches two external tamper pins and records, per channel, whether a tamper condition has been seen since the channel was armed. Each channel has its own configuration register. The register sets whether the channel is armed and whether its flag may raise the interrupt. It also describes how the external switch is wired: it either rests open and closes on tampering, or rests closed and opens on tampering. A last bit gives the rail the pin reaches while tampered. The pins are brought into the clock domain through a synchronizer chain. Each channel then compares its synchronized pin level against its configured tampered state.

Once a channel's flag is set, it stays set until software disarms that channel. Reading the flags does not clear them, and writing to the flags register does not clear them either. The two flags are read together from one register. A shared interrupt line reports any flag whose interrupt enable is set. While the system runs from its backup supply, that line is held off unless a global backup-interrupt enable bit is set.

Top module: `tamper_guard`

## Requirements
- R1: After synchronous reset, every register reads 0, both tamper flags are 0 and `irq` is 0.
- R2: Channel 1 configuration is at address 1 and channel 2 at address 2, with bit 0 = arm, bit 1 = interrupt enable, bit 2 = wiring (1 = rests open, 0 = rests closed), bit 3 = tampered rail (1 = high, 0 = low); upper bits read 0. Address 3 bit 0 is the backup-interrupt enable. Writes with `wr_en` high take effect at the next clock edge and read back unchanged.
- R3: With wiring = 1, a channel sees tampering while its synchronized pin equals the tampered rail bit.
- R4: With wiring = 0, a channel sees tampering while its synchronized pin differs from the tampered rail bit.
- R5: When an armed channel sees tampering, its flag is visible at the third rising clock edge after the pin changes (two synchronizer stages and the flag register).
- R6: A channel that is not armed ignores its pin, and its flag stays 0.
- R7: A set flag stays 1 after the pin returns to its resting level, for as long as the channel stays armed.
- R8: A flag clears only when its arm bit is written to 0. Writes to the flags register and reads of any register leave it unchanged.
- R9: Address 0 reads channel 1's flag at bit 0 and channel 2's flag at bit 1, with other bits 0.
- R10: `irq` is 1 exactly when some channel has its flag and its interrupt enable both 1 (subject to R11). Channels do not affect each other's flags.
- R11: While `on_battery` is 1, `irq` is 0 unless the backup-interrupt enable is 1. While `on_battery` is 0, that bit has no effect.
- R12: `irq` stays 1 after the pin returns to rest and falls only when the contributing flag is cleared or its interrupt enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (2) | Register address |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data for `addr`, combinational |
| tamper_pin | input | NUM_CH (2) | Asynchronous tamper pins, bit 0 = channel 1 |
| on_battery | input | 1 | 1 while running from the backup supply |
| irq | output | 1 | Shared tamper interrupt, active high |

## Verification
The bench walks all eight combinations of wiring, tampered rail and pin level. A design that mixed up the rests-open and rests-closed decodes would set flags in exactly the wrong half of them. It measures flag latency edge by edge, so an extra or a missing synchronizer stage shows up as a flag that is one cycle early or late. It writes all-ones to the flags address, reads the flags repeatedly, and lets the pin fall back to rest. A flag that cleared on any of these, rather than only when the channel is disarmed, would be caught. It also drives the backup-supply input with and without the enable bit, and a gate that ignored either term would raise or hold `irq` in the wrong case.

// File: rtl/tamp_pkg.sv
package tamp_pkg;

    // Per-channel configuration word; bit 0 is the arm bit.
    typedef struct packed {
        logic rail_hi;   // bit 3: pin level while tampered
        logic rest_open; // bit 2: 1 = switch rests open, 0 = rests closed
        logic irq_en;    // bit 1
        logic arm;       // bit 0
    } chan_cfg_t;

    localparam int CFG_W      = $bits(chan_cfg_t);
    localparam int FLAGS_ADDR = 0;

    // Tampered when (rests open and pin at rail) or (rests closed and pin off rail).
    function automatic logic tamper_seen(input logic pin, input chan_cfg_t c);
        return pin ^ c.rail_hi ^ c.rest_open;
    endfunction

endpackage

// File: rtl/tamp_sync.sv
module tamp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/tamp_regs.sv
module tamp_regs
    import tamp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 2,
    parameter int DW     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [NUM_CH-1:0]       flags,
    output chan_cfg_t [NUM_CH-1:0]  cfg,
    output logic                    batt_irq_en,
    output logic [DW-1:0]           rdata
);
    localparam int BATT_ADDR = NUM_CH + 1;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg[i] <= '0;
            else if (wr_en && addr == AW'(i + 1))
                cfg[i] <= chan_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            batt_irq_en <= 1'b0;
        else if (wr_en && addr == AW'(BATT_ADDR))
            batt_irq_en <= wdata[0];
    end

    // Flags address is read-only: no write path exists for it.
    always_comb begin
        rdata = '0;
        if (addr == AW'(FLAGS_ADDR)) rdata[NUM_CH-1:0] = flags;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == AW'(i + 1)) rdata[CFG_W-1:0] = cfg[i];
        if (addr == AW'(BATT_ADDR)) rdata[0] = batt_irq_en;
    end
endmodule

// File: rtl/tamp_chan.sv
module tamp_chan
    import tamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_cfg_t cfg,
    input  logic      pin_s,
    output logic      flag
);
    logic hit;
    assign hit = tamper_seen(pin_s, cfg);

    always_ff @(posedge clk) begin
        if (rst || !cfg.arm)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
    end

    AST_CLEAR_WHEN_DISARMED: assert property (@(posedge clk) disable iff (rst)
        $past(!cfg.arm) |-> !flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg.arm && $past(cfg.arm) && $past(flag)) |-> flag); // R7
    AST_SET_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cfg.arm && hit)); // R5
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tamp_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int AW          = 2,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NUM_CH-1:0] tamper_pin,
    input  logic              on_battery,
    output logic              irq
);
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      pin_s;
    logic [NUM_CH-1:0]      flags;
    logic [NUM_CH-1:0]      ie_vec;
    logic                   batt_irq_en;

    tamp_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(tamper_pin), .q(pin_s)
    );

    tamp_regs #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flags(flags), .cfg(cfg), .batt_irq_en(batt_irq_en), .rdata(rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tamp_chan u_chan (
            .clk(clk), .rst(rst), .cfg(cfg[i]), .pin_s(pin_s[i]), .flag(flags[i])
        );
        assign ie_vec[i] = cfg[i].irq_en;
    end

    assign irq = (|(flags & ie_vec)) && (!on_battery || batt_irq_en);

    AST_BATT_GATE: assert property (@(posedge clk) disable iff (rst)
        (on_battery && !batt_irq_en) |-> !irq); // R11
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(flags & ie_vec)); // R10
    AST_FLAGS_ZERO_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0)); // R1
endmodule

// File: tb/sim_tamper_guard.sv
`timescale 1ns/1ps
module sim_tamper_guard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] tamper_pin = '0;
    logic       on_battery = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tamper_guard u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tamper_pin(tamper_pin), .on_battery(on_battery), .irq(irq)
    );

    // {rest_open, rail_hi, pin, expected flag}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0011, 4'b0101, 4'b0110,
        4'b1001, 4'b1010, 4'b1100, 4'b1111
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
        addr = 2'd0;
    endtask

    function automatic logic [7:0] cfgw(input logic rail, input logic ropen,
                                        input logic ie, input logic arm);
        return {4'b0, rail, ropen, ie, arm};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tamper_pin = '0; on_battery = 1'b0;
        wait_n(2); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        do_reset();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reg after reset", d, 0);
        end
        #1 chk("R1 irq after reset", irq, 0);

        // R2: register map and readback
        wr(2'd1, 8'h0E); rd(2'd1, d); chk("R2 ch1 readback", d, 8'h0E);
        wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 ch2 upper bits", d, 8'h0F);
        wr(2'd3, 8'hFF); rd(2'd3, d); chk("R2 batt enable readback", d, 8'h01);
        do_reset();

        // R3/R4: decode table on channel 1
        for (int v = 0; v < 8; v++) begin
            wr(2'd1, cfgw(VEC[v][2], VEC[v][3], 1'b0, 1'b0));
            tamper_pin[0] = VEC[v][1];
            wait_n(4);
            wr(2'd1, cfgw(VEC[v][2], VEC[v][3], 1'b0, 1'b1));
            wait_n(2);
            rd(2'd0, d);
            chk(VEC[v][3] ? "R3 rests-open decode" : "R4 rests-closed decode",
                d[0], VEC[v][0]);
            wr(2'd1, 8'h00);
            tamper_pin[0] = 1'b0;
            wait_n(3);
        end
        do_reset();

        // R5: latency, rests open, tampered high
        wr(2'd1, cfgw(1'b1, 1'b1, 1'b0, 1'b1));
        wait_n(3);
        tamper_pin[0] = 1'b1;
        wait_n(2); rd(2'd0, d); chk("R5 flag not yet after 2 edges", d[0], 0);
        wait_n(1); rd(2'd0, d); chk("R5 flag after 3 edges", d[0], 1);

        // R7: sticky after pin returns to rest
        tamper_pin[0] = 1'b0;
        wait_n(6); rd(2'd0, d); chk("R7 flag sticky", d[0], 1);

        // R8: flags write ignored, reads do not clear
        wr(2'd0, 8'h00); rd(2'd0, d); chk("R8 write 0 to flags ignored", d, 8'h01);
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R8 write FF to flags ignored", d, 8'h01);
        for (int k = 0; k < 4; k++) begin
            wait_n(1); rd(2'd0, d);
        end
        chk("R8 reads do not clear", d, 8'h01);

        // R9: bit positions, channel 2 alone then both
        wr(2'd2, cfgw(1'b1, 1'b1, 1'b0, 1'b1));
        wr(2'd1, 8'h00);
        wait_n(2); rd(2'd0, d); chk("R8 disarm clears flag", d, 8'h00);
        tamper_pin[1] = 1'b1;
        wait_n(4); rd(2'd0, d); chk("R9 ch2 flag at bit 1", d, 8'h02);
        wr(2'd1, cfgw(1'b1, 1'b1, 1'b0, 1'b1));
        tamper_pin[0] = 1'b1;
        wait_n(4); rd(2'd0, d); chk("R9 both flags", d, 8'h03);
        tamper_pin = 2'b00;
        wr(2'd1, 8'h00);
        wait_n(2); rd(2'd0, d); chk("R10 ch2 unaffected by ch1 clear", d, 8'h02);

        // R10/R12: interrupt from channel 2
        #1 chk("R10 no irq without enable", irq, 0);
        wr(2'd2, cfgw(1'b1, 1'b1, 1'b1, 1'b1));
        #1 chk("R10 irq with enable", irq, 1);
        wait_n(5);
        #1 chk("R12 irq held after pin rest", irq, 1);
        wr(2'd2, cfgw(1'b1, 1'b1, 1'b1, 1'b0));
        wait_n(1);
        #1 chk("R12 irq falls when flag cleared", irq, 0);

        // R6: disarmed channel ignores its pin
        tamper_pin[1] = 1'b1;
        wait_n(6); rd(2'd0, d); chk("R6 disarmed flag stays 0", d, 8'h00);
        #1 chk("R6 disarmed no irq", irq, 0);
        tamper_pin[1] = 1'b0;

        // R11: backup supply gating with channel 1
        wr(2'd1, cfgw(1'b0, 1'b1, 1'b1, 1'b1));
        tamper_pin[0] = 1'b0;
        wait_n(4);
        #1 chk("R11 irq on main supply", irq, 1);
        on_battery = 1'b1;
        #1 chk("R11 irq blocked on battery", irq, 0);
        wr(2'd3, 8'h01);
        #1 chk("R11 irq allowed on battery", irq, 1);
        on_battery = 1'b0;
        wr(2'd3, 8'h00);
        #1 chk("R11 enable irrelevant on main", irq, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule